// File: doc/BRIEF.md
# Timer-Clocked Asynchronous Serial Port

This block is an 8-bit asynchronous serial transceiver. A frame is one low start bit, eight data bits sent least significant bit first, and one high stop bit. The block has no baud divisor of its own. It counts overflow pulses from an external timer. Two pulses make one sub-sample in normal rate, and one pulse makes one sub-sample in doubled rate. Sixteen sub-samples make one bit. So the bit rate is the overflow rate divided by 32, or by 16 when the doubling bit is set. For example, a timer that runs at 921.6 kHz and overflows every 3 counts gives 9600 bit/s.

Software uses two 8-bit registers, chosen by `regSel`:
- The data register (`regSel` = 0). A write starts a transmission. A read returns the last byte that was accepted.
- The control register (`regSel` = 1), laid out as follows:
  - bits [7:6]: mode. The value 01 selects 8-bit asynchronous operation, and no other mode value moves either serial pin.
  - bit [5]: spare.
  - bit [4]: receive enable.
  - bit [3]: spare.
  - bit [2]: rate doubling.
  - bit [1]: transmit-done.
  - bit [0]: receive-done.

The value 50h selects asynchronous mode with the receiver on. Hardware sets the two done flags. Only a control write clears them. The interrupt request is high while either flag is set.

The receiver synchronises the RX line and samples it at every sub-sample. It confirms a start bit with a three-sample majority vote around the middle of the bit, and it takes each data bit and the stop bit the same way. A byte is accepted only when receive-done is clear and the stop bit is high. After a low stop bit, the receiver waits for the line to go high before it looks for a new start bit.

Top module: `tick_uart`

## Requirements
- R1: After reset, `txPin` is 1, `irq` is 0, and both registers read 00h.
- R2: In mode 01, a data write drives this frame on `txPin`: a low start bit, the eight data bits least significant bit first, then a high stop bit. With the doubling bit clear, each bit lasts 32 `tick` pulses. `txPin` is high whenever no frame is in progress.
- R3: With the doubling bit (control bit 2) set, each transmitted and received bit lasts 16 `tick` pulses.
- R4: Transmit-done (control bit 1) stays clear until the stop bit has finished. It is then set, and it stays set until a control write clears it.
- R5: With mode 01 and receive enable (control bit 4) set, a valid incoming frame makes the byte readable in the data register and sets receive-done (control bit 0).
- R6: A frame that completes while receive-done is set is discarded. The data register and the flag are left unchanged.
- R7: A frame whose stop bit is low is discarded, and receive-done stays clear. The receiver then waits for the line to return high before it accepts a new start bit.
- R8: While receive enable is clear, incoming frames are ignored.
- R9: A low pulse shorter than half a bit is rejected as a false start, and the next valid frame is still received.
- R10: `irq` is 1 exactly while transmit-done or receive-done is set.
- R11: A data write while the mode field is not 01 leaves `txPin` high and transmit-done clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle timer overflow pulse |
| regWrEn | input | 1 | Register write strobe |
| regSel | input | 1 | 0 selects the data register, 1 selects the control register |
| regWrData | input | 8 | Write data |
| regRdData | output | 8 | Read data of the selected register |
| rxPin | input | 1 | Serial receive line |
| txPin | output | 1 | Serial transmit line |
| irq | output | 1 | Interrupt request, high while either done flag is set |

## Verification
The bench uses the default parameters: an 8-bit byte and 16 sub-samples per bit. It drives one timer pulse every third clock, so a bit lasts 96 clocks, or 48 clocks when the doubling bit is set. With bits this short, one run can cover both rates in each direction, as well as every reject path of the receiver. These paths are the overrun discard, the low stop bit followed by a held-low line, the disabled receiver, and the short false start. A monitor decodes `txPin` at bit centres timed from the requirements. Any error in the divider or in the bit order therefore shows up as a byte mismatch.

// File: rtl/tick_uart_pkg.sv
`timescale 1ns/1ps
package tick_uart_pkg;
  localparam int REG_W = 8;
  localparam logic [1:0] MODE_ASYNC8 = 2'b01;
  localparam int MODE_HI = 7;
  localparam int MODE_LO = 6;
  localparam int RXEN_BIT = 4;
  localparam int DBL_BIT = 2;
  localparam int TXDONE_BIT = 1;
  localparam int RXDONE_BIT = 0;

  typedef enum logic [2:0] {
    RX_IDLE, RX_START, RX_DATA, RX_STOP, RX_BREAK
  } rxState_t;

  typedef struct packed {
    logic subTick;
    logic txLoad;
    logic txShift;
    logic txDoneSet;
    logic rxSample;
    logic rxCommit;
  } uartStrobe_t;
endpackage

// File: rtl/tick_uart_ctrl.sv
`timescale 1ns/1ps
module tick_uart_ctrl
  import tick_uart_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int SUBS = 16
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        tick,
  input  logic        dataWr,
  input  logic        modeOk,
  input  logic        rxEn,
  input  logic        dblRate,
  input  logic        rxDoneFlag,
  input  logic        rxLine,
  input  logic        rxMaj,
  output uartStrobe_t strobe,
  output logic        txBusy,
  output rxState_t    rxState
);
  localparam int FRAME_BITS = DATA_W + 2;
  localparam int SUB_W = $clog2(SUBS);
  localparam int BIT_W = $clog2(FRAME_BITS);
  localparam int DBIT_W = $clog2(DATA_W);
  localparam int MID = SUBS / 2 + 1;

  logic preHalf;
  logic subTick;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) preHalf <= 1'b0;
    else if (tick) preHalf <= ~preHalf;
  end
  assign subTick = tick & (dblRate | preHalf);

  // transmit sequencing
  logic [SUB_W-1:0] txSub;
  logic [BIT_W-1:0] txBit;
  logic txStart, txBitEnd, txLast;
  assign txStart  = dataWr & modeOk & ~txBusy;
  assign txBitEnd = txBusy & subTick & (txSub == SUB_W'(SUBS - 1));
  assign txLast   = txBitEnd & (txBit == BIT_W'(FRAME_BITS - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txBusy <= 1'b0;
      txSub  <= '0;
      txBit  <= '0;
    end else if (txStart) begin
      txBusy <= 1'b1;
      txSub  <= '0;
      txBit  <= '0;
    end else if (txBusy && subTick) begin
      txSub <= txBitEnd ? '0 : txSub + 1'b1;
      if (txBitEnd) txBit <= txBit + 1'b1;
      if (txLast) txBusy <= 1'b0;
    end
  end

  // receive sequencing
  logic [SUB_W-1:0] rxSub;
  logic [DBIT_W-1:0] rxBit;
  logic rxActive, rxMid, rxEnd;
  logic [SUB_W-1:0] rxSubNext;
  assign rxActive  = modeOk & rxEn;
  assign rxMid     = subTick & (rxSub == SUB_W'(MID));
  assign rxEnd     = subTick & (rxSub == SUB_W'(SUBS - 1));
  assign rxSubNext = rxEnd ? '0 : rxSub + 1'b1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxState <= RX_IDLE;
      rxSub   <= '0;
      rxBit   <= '0;
    end else begin
      case (rxState)
        RX_IDLE: begin
          if (subTick && rxActive && !rxLine) begin
            rxState <= RX_START;
            rxSub   <= SUB_W'(1);
          end
        end
        RX_START: begin
          if (subTick) rxSub <= rxSubNext;
          if (rxMid && rxMaj) rxState <= RX_IDLE;
          else if (rxEnd) begin
            rxState <= RX_DATA;
            rxBit   <= '0;
          end
        end
        RX_DATA: begin
          if (subTick) rxSub <= rxSubNext;
          if (rxEnd) begin
            rxBit <= rxBit + 1'b1;
            if (rxBit == DBIT_W'(DATA_W - 1)) rxState <= RX_STOP;
          end
        end
        RX_STOP: begin
          if (subTick) rxSub <= rxSubNext;
          if (rxMid) rxState <= rxMaj ? RX_IDLE : RX_BREAK;
        end
        RX_BREAK: begin
          if (rxLine) rxState <= RX_IDLE;
        end
        default: rxState <= RX_IDLE;
      endcase
    end
  end

  always_comb begin
    strobe.subTick   = subTick;
    strobe.txLoad    = txStart;
    strobe.txShift   = txBitEnd;
    strobe.txDoneSet = txLast;
    strobe.rxSample  = (rxState == RX_DATA) & rxMid;
    strobe.rxCommit  = (rxState == RX_STOP) & rxMid & rxMaj & ~rxDoneFlag;
  end
endmodule

// File: rtl/tick_uart_dp.sv
`timescale 1ns/1ps
module tick_uart_dp
  import tick_uart_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  uartStrobe_t       strobe,
  input  logic              regWrEn,
  input  logic              regSel,
  input  logic [REG_W-1:0]  regWrData,
  output logic [REG_W-1:0]  regRdData,
  input  logic              rxPin,
  output logic              txPin,
  output logic              irq,
  output logic              modeOk,
  output logic              rxEn,
  output logic              dblRate,
  output logic              txDoneFlag,
  output logic              rxDoneFlag,
  output logic              rxLine,
  output logic              rxMaj,
  output logic [DATA_W-1:0] rxBuf
);
  localparam int FRAME_BITS = DATA_W + 2;

  logic ctrlWr;
  logic [REG_W-1:2] ctrlHi;
  assign ctrlWr = regWrEn & regSel;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlHi     <= '0;
      txDoneFlag <= 1'b0;
      rxDoneFlag <= 1'b0;
    end else begin
      if (ctrlWr) ctrlHi <= regWrData[REG_W-1:2];
      if (strobe.txDoneSet) txDoneFlag <= 1'b1;
      else if (ctrlWr) txDoneFlag <= regWrData[TXDONE_BIT];
      if (strobe.rxCommit) rxDoneFlag <= 1'b1;
      else if (ctrlWr) rxDoneFlag <= regWrData[RXDONE_BIT];
    end
  end

  assign modeOk  = (ctrlHi[MODE_HI:MODE_LO] == MODE_ASYNC8);
  assign rxEn    = ctrlHi[RXEN_BIT];
  assign dblRate = ctrlHi[DBL_BIT];
  assign irq     = txDoneFlag | rxDoneFlag;

  // line synchroniser and 3-sample history
  logic [1:0] rxSync;
  logic [1:0] hist;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxSync <= 2'b11;
      hist   <= 2'b11;
    end else begin
      rxSync <= {rxSync[0], rxPin};
      if (strobe.subTick) hist <= {hist[0], rxSync[1]};
    end
  end
  assign rxLine = rxSync[1];
  assign rxMaj  = (hist[1] & hist[0]) | (hist[1] & rxLine) | (hist[0] & rxLine);

  logic [DATA_W-1:0] rxShreg;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxShreg <= '0;
      rxBuf   <= '0;
    end else begin
      if (strobe.rxSample) rxShreg <= {rxMaj, rxShreg[DATA_W-1:1]};
      if (strobe.rxCommit) rxBuf <= rxShreg;
    end
  end

  logic [FRAME_BITS-1:0] txShreg;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) txShreg <= '1;
    else if (strobe.txLoad) txShreg <= {1'b1, regWrData[DATA_W-1:0], 1'b0};
    else if (strobe.txShift) txShreg <= {1'b1, txShreg[FRAME_BITS-1:1]};
  end
  assign txPin = txShreg[0];

  assign regRdData = regSel ? {ctrlHi, txDoneFlag, rxDoneFlag} : rxBuf;
endmodule

// File: rtl/tick_uart.sv
`timescale 1ns/1ps
module tick_uart
  import tick_uart_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int SUBS = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       tick,
  input  logic       regWrEn,
  input  logic       regSel,
  input  logic [7:0] regWrData,
  output logic [7:0] regRdData,
  input  logic       rxPin,
  output logic       txPin,
  output logic       irq
);
  uartStrobe_t strobe;
  rxState_t rxState;
  logic txBusy, modeOk, rxEn, dblRate, txDoneFlag, rxDoneFlag, rxLine, rxMaj;
  logic [DATA_W-1:0] rxBuf;
  logic dataWr;
  assign dataWr = regWrEn & ~regSel;

  tick_uart_ctrl #(.DATA_W(DATA_W), .SUBS(SUBS)) ctrl_i (
    .clk(clk), .rstN(rstN), .tick(tick), .dataWr(dataWr), .modeOk(modeOk),
    .rxEn(rxEn), .dblRate(dblRate), .rxDoneFlag(rxDoneFlag), .rxLine(rxLine),
    .rxMaj(rxMaj), .strobe(strobe), .txBusy(txBusy), .rxState(rxState)
  );

  tick_uart_dp #(.DATA_W(DATA_W)) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .regWrEn(regWrEn), .regSel(regSel),
    .regWrData(regWrData), .regRdData(regRdData), .rxPin(rxPin), .txPin(txPin),
    .irq(irq), .modeOk(modeOk), .rxEn(rxEn), .dblRate(dblRate),
    .txDoneFlag(txDoneFlag), .rxDoneFlag(rxDoneFlag), .rxLine(rxLine),
    .rxMaj(rxMaj), .rxBuf(rxBuf)
  );
endmodule

// File: rtl/tick_uart_chk.sv
`timescale 1ns/1ps
module tick_uart_chk
  import tick_uart_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              regWrEn,
  input logic              regSel,
  input logic              txPin,
  input logic              irq,
  input logic              txBusy,
  input logic              modeOk,
  input logic              rxEn,
  input logic              txDoneFlag,
  input logic              rxDoneFlag,
  input logic [DATA_W-1:0] rxBuf,
  input rxState_t          rxState,
  input uartStrobe_t       strobe
);
  assert_tx_idle_high_R2: assert property (@(posedge clk) disable iff (!rstN)
    !txBusy |-> txPin);

  assert_txdone_after_frame_R4: assert property (@(posedge clk) disable iff (!rstN)
    strobe.txDoneSet |=> (!txBusy && txDoneFlag));

  assert_txdone_sticky_R4: assert property (@(posedge clk) disable iff (!rstN)
    (txDoneFlag && !(regWrEn && regSel)) |=> txDoneFlag);

  assert_rx_overrun_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    (rxDoneFlag && !(regWrEn && regSel)) |=> (rxDoneFlag && $stable(rxBuf)));

  assert_rx_disabled_idle_R8: assert property (@(posedge clk) disable iff (!rstN)
    (rxState == RX_IDLE && !(modeOk && rxEn)) |=> (rxState == RX_IDLE));

  assert_irq_source_R10: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irq) |-> $past(strobe.txDoneSet || strobe.rxCommit || (regWrEn && regSel)));
endmodule

bind tick_uart tick_uart_chk #(.DATA_W(DATA_W)) chk_i (
  .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regSel(regSel), .txPin(txPin),
  .irq(irq), .txBusy(txBusy), .modeOk(modeOk), .rxEn(rxEn),
  .txDoneFlag(txDoneFlag), .rxDoneFlag(rxDoneFlag), .rxBuf(rxBuf),
  .rxState(rxState), .strobe(strobe)
);

// File: tb/tick_uart_tb.sv
`timescale 1ns/1ps
module tick_uart_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic tick = 1'b0;
  logic regWrEn = 1'b0;
  logic regSel = 1'b0;
  logic [7:0] regWrData = 8'h00;
  logic [7:0] regRdData;
  logic rxPin = 1'b1;
  logic txPin;
  logic irq;

  int nCompared = 0;
  int nMismatched = 0;
  int bitNs = 96 * CLK_PERIOD;
  logic [7:0] txExp[$];

  tick_uart dut_i (
    .clk(clk), .rstN(rstN), .tick(tick), .regWrEn(regWrEn), .regSel(regSel),
    .regWrData(regWrData), .regRdData(regRdData), .rxPin(rxPin),
    .txPin(txPin), .irq(irq)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  // timer overflow: one pulse every third clock
  initial begin
    forever begin
      @(negedge clk) tick = 1'b1;
      @(negedge clk) tick = 1'b0;
      @(negedge clk);
    end
  end

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    nCompared++;
    if (act !== exp) begin
      nMismatched++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wrReg(input logic sel, input logic [7:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regSel = sel; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rdReg(input logic sel, output logic [7:0] d);
    @(negedge clk);
    regSel = sel;
    #1 d = regRdData;
  endtask

  // transmit driver: push expectation, start frame, track done flag
  task automatic txFrame(input logic [7:0] d, input logic [7:0] base, input string req);
    logic [7:0] r;
    txExp.push_back(d);
    wrReg(1'b0, d);
    #(bitNs * 19 / 2);
    rdReg(1'b1, r); check({req, "/R4 done clear mid stop"}, r, base);
    #(bitNs);
    rdReg(1'b1, r); check("R4 done set", r, base | 8'h02);
    check("R10 irq from tx", {7'b0, irq}, 8'h01);
    #(2 * bitNs);
    rdReg(1'b1, r); check("R4 done sticky", r, base | 8'h02);
    wrReg(1'b1, base);
    rdReg(1'b1, r); check("R4 cleared by write", r, base);
    check("R10 irq low", {7'b0, irq}, 8'h00);
  endtask

  // receive driver
  task automatic rxFrame(input logic [7:0] d, input logic stopVal);
    @(negedge clk);
    rxPin = 1'b0;
    #(bitNs);
    for (int i = 0; i < 8; i++) begin
      rxPin = d[i];
      #(bitNs);
    end
    rxPin = stopVal;
    #(bitNs);
    if (!stopVal) #(bitNs);
    rxPin = 1'b1;
    #(bitNs);
  endtask

  // monitor: decode txPin and compare with the scoreboard queue
  initial begin
    logic [7:0] got;
    logic [7:0] want;
    logic sb;
    forever begin
      @(negedge txPin);
      if (txExp.size() == 0) begin
        nCompared++; nMismatched++;
        $display("FAIL R11: actual start bit expected idle line at %0t", $time);
      end else begin
        want = txExp.pop_front();
        #(bitNs / 2 + 3);
        check("R2 start bit", {7'b0, txPin}, 8'h00);
        for (int i = 0; i < 8; i++) begin
          #(bitNs);
          got[i] = txPin;
        end
        #(bitNs);
        sb = txPin;
        check("R2/R3 tx byte", got, want);
        check("R2 stop bit", {7'b0, sb}, 8'h01);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 190000);
    nCompared++; nMismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCompared, nMismatched);
    $finish;
  end

  initial begin
    logic [7:0] r;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 txPin", {7'b0, txPin}, 8'h01);
    check("R1 irq", {7'b0, irq}, 8'h00);
    rdReg(1'b1, r); check("R1 control", r, 8'h00);
    rdReg(1'b0, r); check("R1 data", r, 8'h00);

    // R11 write with mode not asynchronous
    wrReg(1'b0, 8'hA5);
    #(12 * bitNs);
    check("R11 txPin idle", {7'b0, txPin}, 8'h01);
    rdReg(1'b1, r); check("R11 no done", r, 8'h00);

    wrReg(1'b1, 8'h50);
    rdReg(1'b1, r); check("R5 control 50h", r, 8'h50);

    // R2 normal rate transmit
    txFrame(8'h3C, 8'h50, "R2");
    txFrame(8'h81, 8'h50, "R2");

    // R3 doubled rate
    wrReg(1'b1, 8'h54);
    bitNs = 48 * CLK_PERIOD;
    #(bitNs);
    txFrame(8'hC3, 8'h54, "R3");
    rxFrame(8'h6E, 1'b1);
    rdReg(1'b0, r); check("R3 rx byte doubled", r, 8'h6E);
    rdReg(1'b1, r); check("R3 rx done doubled", r, 8'h55);
    wrReg(1'b1, 8'h50);
    bitNs = 96 * CLK_PERIOD;
    #(bitNs);

    // R5 receive
    rxFrame(8'h5A, 1'b1);
    rdReg(1'b0, r); check("R5 rx byte", r, 8'h5A);
    rdReg(1'b1, r); check("R5 rx done", r, 8'h51);
    check("R10 irq from rx", {7'b0, irq}, 8'h01);

    // R6 overrun discard
    rxFrame(8'h77, 1'b1);
    rdReg(1'b0, r); check("R6 data kept", r, 8'h5A);
    rdReg(1'b1, r); check("R6 flag kept", r, 8'h51);
    wrReg(1'b1, 8'h50);
    check("R10 irq cleared", {7'b0, irq}, 8'h00);

    // R7 low stop bit, line held low
    rxFrame(8'h99, 1'b0);
    #(2 * bitNs);
    rdReg(1'b1, r); check("R7 no done", r, 8'h50);
    rdReg(1'b0, r); check("R7 data kept", r, 8'h5A);

    // R8 receiver disabled
    wrReg(1'b1, 8'h40);
    rxFrame(8'h11, 1'b1);
    rdReg(1'b1, r); check("R8 no done", r, 8'h40);
    rdReg(1'b0, r); check("R8 data kept", r, 8'h5A);
    wrReg(1'b1, 8'h50);

    // R9 false start then valid frame
    @(negedge clk);
    rxPin = 1'b0;
    #(20 * CLK_PERIOD);
    rxPin = 1'b1;
    #(2 * bitNs);
    rdReg(1'b1, r); check("R9 glitch ignored", r, 8'h50);
    rxFrame(8'h42, 1'b1);
    rdReg(1'b0, r); check("R9 next frame byte", r, 8'h42);
    rdReg(1'b1, r); check("R9 next frame done", r, 8'h51);

    check("R2 scoreboard drained", 8'(txExp.size()), 8'h00);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCompared, nMismatched);
    $finish;
  end
endmodule